// File: doc/BRIEF.md
# Activity-Driven Power State Stepper

This block watches for system activity and, as idle time accumulates, walks a four-level power state from fully on, through doze and standby, down to suspend. Each descent uses its own programmable timeout. The timeouts are counted in prescaled ticks. A free timebase tick is divided by a parameter, and the divider restarts whenever system activity is seen. Any system activity brings the block straight back to the fully-on state and restarts idle timing.

Background (housekeeping) activity is detected on a separate input. In doze or standby, a housekeeping pulse opens a service window of programmable length. During that window the idle countdown is frozen, and the block does not wake to the fully-on state. When the window closes, the block stays in the same low-power state and the countdown resumes from where it stopped. A one-cycle interrupt marks every state change. The new state code is visible on the state output in the same cycle as the interrupt.

Top module: `pwr_idle_stepper`

## Requirements
- R1: After reset the state output reads 0 (on), and the interrupt and service outputs are low.
- R2: With master enable high and no activity, the state goes from on (0) to doze (1) in the cycle after the clock edge that samples the `to_doze_i`-th prescaled tick. A prescaled tick is every PRESC_DIV-th timebase tick, counted from reset or from the last system activity.
- R3: Doze steps to standby (2) after `to_stby_i` prescaled ticks. Standby steps to suspend (3) after `to_susp_i` prescaled ticks. Suspend is held until system activity arrives. A step only ever moves one level deeper.
- R4: A system activity pulse in any state sets the state to on in the next cycle and reloads the doze timeout in full.
- R5: `irq_o` is high for exactly one cycle whenever the state changes, in the same cycle as the new state. It is low in every other cycle.
- R6: A housekeeping pulse in doze or standby raises `hk_svc_o` in the next cycle and freezes the idle countdown. After `to_hk_i` prescaled ticks `hk_svc_o` falls, the state is unchanged, and the countdown resumes from its frozen value.
- R7: Housekeeping pulses in on or suspend are ignored: `hk_svc_o` stays low and idle timing is unaffected.
- R8: A timeout of zero disables that step, and the block stays in the current state however many ticks arrive.
- R9: When system and housekeeping activity arrive in the same cycle, system activity wins: the state goes to on and `hk_svc_o` stays low.
- R10: While `pm_en_i` is low, no countdown advances and the state does not change except through system activity.
- R11: A housekeeping pulse during an open service window reloads the window to its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pm_en_i | input | 1 | Master enable for all countdowns |
| sys_act_i | input | 1 | System activity pulse |
| hk_act_i | input | 1 | Housekeeping activity pulse |
| tb_tick_i | input | 1 | Timebase tick before prescaling |
| to_doze_i | input | CNT_W | Prescaled ticks from on to doze, 0 disables |
| to_stby_i | input | CNT_W | Prescaled ticks from doze to standby, 0 disables |
| to_susp_i | input | CNT_W | Prescaled ticks from standby to suspend, 0 disables |
| to_hk_i | input | CNT_W | Service window length in prescaled ticks, 0 disables housekeeping |
| state_o | output | 2 | Power state: 0 on, 1 doze, 2 standby, 3 suspend |
| irq_o | output | 1 | One-cycle pulse on each state change |
| hk_svc_o | output | 1 | Housekeeping service window open |

## Verification
The assertions assume that reset is held for at least one clock edge before release. They also assume that the activity inputs are ordinary synchronous levels sampled at the clock edge. Without this, the comparison of the state with its previous value would have no defined starting point. The bench drives every input at the falling edge and holds reset for several cycles. It keeps the timeout inputs constant while a countdown that uses them is running, and changes a timeout only just before a system activity pulse reloads the timers. This keeps every countdown length known in advance.

// File: rtl/pis_pkg.sv
package pis_pkg;

   typedef enum logic [1:0] {
      PS_ON   = 2'd0,
      PS_DOZE = 2'd1,
      PS_STBY = 2'd2,
      PS_SUSP = 2'd3
   } pis_state_e;

   function automatic pis_state_e pis_deeper(input pis_state_e s);
      case (s)
         PS_ON:   pis_deeper = PS_DOZE;
         PS_DOZE: pis_deeper = PS_STBY;
         default: pis_deeper = PS_SUSP;
      endcase
   endfunction

endpackage

// File: rtl/pis_prescale.sv
module pis_prescale #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic tick_i,
   input  logic restart_i,
   output logic ptick_o
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [PW-1:0] pc;
   logic          wrap;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("pis_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign wrap = 1'b1;
      end else begin : g_div
         assign wrap = (pc == PW'(DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restart_i) begin
         pc <= '0;
      end else if (en_i && tick_i) begin
         pc <= wrap ? '0 : pc + PW'(1);
      end
   end

   assign ptick_o = en_i && tick_i && !restart_i && wrap;
endmodule

// File: rtl/pis_step_sel.sv
module pis_step_sel
   import pis_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  pis_state_e       state_i,
   input  logic [CNT_W-1:0] to_doze_i,
   input  logic [CNT_W-1:0] to_stby_i,
   input  logic [CNT_W-1:0] to_susp_i,
   output logic [CNT_W-1:0] cur_to_o,
   output logic [CNT_W-1:0] nxt_to_o
);
   always_comb begin
      case (state_i)
         PS_ON: begin
            cur_to_o = to_doze_i;
            nxt_to_o = to_stby_i;
         end
         PS_DOZE: begin
            cur_to_o = to_stby_i;
            nxt_to_o = to_susp_i;
         end
         PS_STBY: begin
            cur_to_o = to_susp_i;
            nxt_to_o = '0;
         end
         default: begin
            cur_to_o = '0;
            nxt_to_o = '0;
         end
      endcase
   end
endmodule

// File: rtl/pis_hk_timer.sv
module pis_hk_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             clear_i,
   input  logic             ptick_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         cnt    <= '0;
         busy_o <= 1'b0;
      end else if (load_i) begin
         cnt    <= len_i;
         busy_o <= 1'b1;
      end else if (busy_o && ptick_i) begin
         if (cnt <= CNT_W'(1)) begin
            busy_o <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/pwr_idle_stepper.sv
module pwr_idle_stepper
   import pis_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int PRESC_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pm_en_i,
   input  logic             sys_act_i,
   input  logic             hk_act_i,
   input  logic             tb_tick_i,
   input  logic [CNT_W-1:0] to_doze_i,
   input  logic [CNT_W-1:0] to_stby_i,
   input  logic [CNT_W-1:0] to_susp_i,
   input  logic [CNT_W-1:0] to_hk_i,
   output logic [1:0]       state_o,
   output logic             irq_o,
   output logic             hk_svc_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("pwr_idle_stepper: CNT_W must be at least 2");
      end
   endgenerate

   pis_state_e       st;
   logic [CNT_W-1:0] idle_cnt;
   logic [CNT_W-1:0] cur_to, nxt_to;
   logic             ptick, hk_busy, hk_take, low_pwr, step_on, advance;

   pis_prescale #(.DIV(PRESC_DIV)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (pm_en_i),
      .tick_i    (tb_tick_i),
      .restart_i (sys_act_i),
      .ptick_o   (ptick)
   );

   pis_step_sel #(.CNT_W(CNT_W)) u_sel (
      .state_i   (st),
      .to_doze_i (to_doze_i),
      .to_stby_i (to_stby_i),
      .to_susp_i (to_susp_i),
      .cur_to_o  (cur_to),
      .nxt_to_o  (nxt_to)
   );

   assign low_pwr = (st == PS_DOZE) || (st == PS_STBY);
   assign hk_take = hk_act_i && !sys_act_i && low_pwr && (to_hk_i != '0);

   pis_hk_timer #(.CNT_W(CNT_W)) u_hk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (hk_take),
      .clear_i (sys_act_i),
      .ptick_i (ptick),
      .len_i   (to_hk_i),
      .busy_o  (hk_busy)
   );

   // idle countdown runs only when no wake, no service window, step enabled
   assign step_on = ptick && !sys_act_i && !hk_take && !hk_busy && (cur_to != '0);
   assign advance = step_on && (idle_cnt <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= PS_ON;
         idle_cnt <= to_doze_i;
         irq_o    <= 1'b0;
      end else begin
         irq_o <= (sys_act_i && (st != PS_ON)) || advance;
         if (sys_act_i) begin
            st       <= PS_ON;
            idle_cnt <= to_doze_i;
         end else if (advance) begin
            st       <= pis_deeper(st);
            idle_cnt <= nxt_to;
         end else if (step_on) begin
            idle_cnt <= idle_cnt - ONE;
         end
      end
   end

   assign state_o  = st;
   assign hk_svc_o = hk_busy;
endmodule

// File: rtl/pis_chk.sv
module pis_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pm_en_i,
   input logic       sys_act_i,
   input logic       hk_act_i,
   input logic [1:0] state_o,
   input logic       irq_o,
   input logic       hk_svc_o
);
   AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != $past(state_o)) |-> irq_o); // R5
   AST_IRQ_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (state_o != $past(state_o))); // R5
   AST_WAKE_TO_ON: assert property (@(posedge clk) disable iff (!rst_n)
      sys_act_i |=> (state_o == 2'd0)); // R4
   AST_ONE_LEVEL_DEEPER: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && state_o != 2'd0) |-> (state_o == $past(state_o) + 2'd1)); // R3
   AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3 && !sys_act_i) |=> (state_o == 2'd3)); // R3
   AST_SVC_LOW_PWR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      hk_svc_o |-> (state_o == 2'd1 || state_o == 2'd2)); // R7
   AST_SYS_BEATS_HK: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_act_i && hk_act_i) |=> !hk_svc_o); // R9
   AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!pm_en_i && !sys_act_i) |=> $stable(state_o)); // R10
endmodule

bind pwr_idle_stepper pis_chk u_pis_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pm_en_i   (pm_en_i),
   .sys_act_i (sys_act_i),
   .hk_act_i  (hk_act_i),
   .state_o   (state_o),
   .irq_o     (irq_o),
   .hk_svc_o  (hk_svc_o)
);

// File: tb/pwr_idle_stepper_tb_top.sv
module pwr_idle_stepper_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int DIV        = 2;
   localparam int T_DOZE     = 3;
   localparam int T_STBY     = 2;
   localparam int T_SUSP     = 2;
   localparam int T_HK       = 2;
   localparam int WD_CYCLES  = 20000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pm_en_i = 1'b1;
   logic             sys_act_i = 1'b0;
   logic             hk_act_i = 1'b0;
   logic             tb_tick_i = 1'b0;
   logic [CNT_W-1:0] to_doze_i = CNT_W'(T_DOZE);
   logic [CNT_W-1:0] to_stby_i = CNT_W'(T_STBY);
   logic [CNT_W-1:0] to_susp_i = CNT_W'(T_SUSP);
   logic [CNT_W-1:0] to_hk_i   = CNT_W'(T_HK);
   logic [1:0]       state_o;
   logic             irq_o, hk_svc_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwr_idle_stepper #(.CNT_W(CNT_W), .PRESC_DIV(DIV)) dut_i (
      .clk (clk), .rst_n (rst_n), .pm_en_i (pm_en_i),
      .sys_act_i (sys_act_i), .hk_act_i (hk_act_i), .tb_tick_i (tb_tick_i),
      .to_doze_i (to_doze_i), .to_stby_i (to_stby_i),
      .to_susp_i (to_susp_i), .to_hk_i (to_hk_i),
      .state_o (state_o), .irq_o (irq_o), .hk_svc_o (hk_svc_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_st(input string req, input int exp);
      chk(int'(state_o) == exp, req, "state", int'(state_o), exp);
   endtask

   task automatic chk_irq(input string req, input int exp);
      chk(int'(irq_o) == exp, req, "irq", int'(irq_o), exp);
   endtask

   task automatic chk_svc(input string req, input int exp);
      chk(int'(hk_svc_o) == exp, req, "svc", int'(hk_svc_o), exp);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tb_tick_i = 1'b1;
         @(negedge clk);
      end
      tb_tick_i = 1'b0;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
   endtask

   task automatic pulse_sys();
      sys_act_i = 1'b1;
      @(negedge clk);
      sys_act_i = 1'b0;
   endtask

   task automatic pulse_hk();
      hk_act_i = 1'b1;
      @(negedge clk);
      hk_act_i = 1'b0;
   endtask

   task automatic t_reset();
      chk_st("R1", 0);
      chk_irq("R1", 0);
      chk_svc("R1", 0);
   endtask

   task automatic t_cascade();
      pulse_sys();
      ticks(DIV * T_DOZE - 1);
      chk_st("R2", 0);
      ticks(1);
      chk_st("R2", 1);
      chk_irq("R5", 1);
      idle_cycle();
      chk_irq("R5", 0);
      ticks(DIV * T_STBY - 1);
      chk_st("R3", 1);
      ticks(1);
      chk_st("R3", 2);
      chk_irq("R5", 1);
      ticks(DIV * T_SUSP - 1);
      chk_st("R3", 2);
      ticks(1);
      chk_st("R3", 3);
      ticks(20);
      chk_st("R3", 3);
      chk_irq("R5", 0);
   endtask

   task automatic t_wake();
      pulse_sys();
      chk_st("R4", 0);
      chk_irq("R5", 1);
      idle_cycle();
      chk_irq("R5", 0);
      ticks(DIV * T_DOZE - 1);
      chk_st("R4", 0);
      ticks(1);
      chk_st("R4", 1);
   endtask

   task automatic t_hk_window();
      pulse_hk();
      chk_svc("R6", 1);
      chk_st("R6", 1);
      chk_irq("R6", 0);
      ticks(DIV * T_HK - 1);
      chk_svc("R6", 1);
      ticks(1);
      chk_svc("R6", 0);
      chk_st("R6", 1);
      ticks(DIV * T_STBY - 1);
      chk_st("R6", 1);
      ticks(1);
      chk_st("R6", 2);
   endtask

   task automatic t_hk_retrigger();
      pulse_hk();
      ticks(DIV);
      chk_svc("R11", 1);
      pulse_hk();
      ticks(DIV * T_HK - 1);
      chk_svc("R11", 1);
      ticks(1);
      chk_svc("R11", 0);
      chk_st("R11", 2);
      ticks(DIV * T_SUSP - 1);
      chk_st("R11", 2);
      ticks(1);
      chk_st("R11", 3);
   endtask

   task automatic t_hk_ignored();
      pulse_hk();
      chk_svc("R7", 0);
      chk_st("R7", 3);
      pulse_sys();
      pulse_hk();
      chk_svc("R7", 0);
      ticks(DIV * T_DOZE - 1);
      chk_st("R7", 0);
      ticks(1);
      chk_st("R7", 1);
   endtask

   task automatic t_priority();
      sys_act_i = 1'b1;
      hk_act_i  = 1'b1;
      @(negedge clk);
      sys_act_i = 1'b0;
      hk_act_i  = 1'b0;
      chk_st("R9", 0);
      chk_svc("R9", 0);
      chk_irq("R9", 1);
      ticks(DIV * T_DOZE - 1);
      chk_st("R9", 0);
      ticks(1);
      chk_st("R9", 1);
   endtask

   task automatic t_zero_timeout();
      to_stby_i = '0;
      pulse_sys();
      ticks(DIV * T_DOZE);
      chk_st("R8", 1);
      ticks(30);
      chk_st("R8", 1);
      chk_irq("R8", 0);
      to_stby_i = CNT_W'(T_STBY);
      pulse_sys();
   endtask

   task automatic t_enable_off();
      pulse_sys();
      pm_en_i = 1'b0;
      ticks(20);
      chk_st("R10", 0);
      pm_en_i = 1'b1;
      ticks(DIV * T_DOZE - 1);
      chk_st("R10", 0);
      ticks(1);
      chk_st("R10", 1);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle_cycle();
      t_reset();
      t_cascade();
      t_wake();
      t_hk_window();
      t_hk_retrigger();
      t_hk_ignored();
      t_priority();
      t_zero_timeout();
      t_enable_off();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
         summary();
         $finish;
      end
   end
endmodule